// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits next to the SECDED checker of a DRAM controller and keeps a software-visible record of the memory errors it reports. The checker sends a one-cycle pulse for each correctable or uncorrectable error, along with the failing address. For each error class the block keeps a saturating count and one captured address. For uncorrectable errors it keeps the address of the first error since the last clear. For correctable errors it keeps the address of the most recent one. A level-high interrupt line signals software while any enabled class has logged an error.

Software reaches the block through a plain 32-bit register port made of an address, a write strobe, write data and combinational read data. Offsets are word-aligned. Every register write is refused until a fixed 32-bit key has been written to offset 0x00. Writing the bitwise inverse of the key locks the register set again. A typical handler reads the control/status word and both address registers. It then pulses the clear bit high and low again, which discards the counts and the captured addresses.

Top module: `ecc_errlog`

## Requirements
- R1: After synchronous reset the block is locked, both counts and both captured addresses are zero, the enables and the clear bit are 0, `irq` is low and the configuration register holds its reset parameter (bits 7 and 4 only).
- R2: A write of 0xFC600309 to offset 0x00 unlocks the register set, and a write of 0x039FFCF6 locks it. Any other value written there changes nothing. Reading offset 0x00 returns 1 in bit 0 when unlocked and 0 when locked.
- R3: While the block is locked, writes to offsets 0x04 and 0x50 have no effect. Reads are allowed at all times.
- R4: Offset 0x50 shows the correctable count in bits 23:16 and the uncorrectable count in bits 15:12. Each pulse adds one. The correctable count stops at 255 and the uncorrectable count stops at 15, with no wrap.
- R5: Bit 31 of offset 0x50 is the clear bit and reads back as written. While it is 1, both counts and both addresses are held at zero, and error pulses taken in those cycles are dropped. Counting resumes once it is written back to 0.
- R6: Offset 0x58 holds the address of the first uncorrectable error since reset or clear. Later uncorrectable errors leave it unchanged.
- R7: Offset 0x5C holds the address of the most recent correctable error.
- R8: Bit 0 of offset 0x50 enables correctable errors and bit 1 enables uncorrectable errors. `irq` is high exactly when an enabled class has a nonzero count, and it remains high until the count is cleared or the enable is removed.
- R9: At offset 0x04, bit 7 means ECC mode on and bit 4 selects the DRAM type (1 = DDR4, 0 = DDR3). Both bits are writable when unlocked. All other bits read 0.
- R10: Reads of unmapped offsets return zero. The unused bits of offset 0x50 read zero, and counts written through the bus are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ce_hit | input | 1 | Correctable error pulse |
| ce_addr | input | ERR_AW | Address of the correctable error |
| ue_hit | input | 1 | Uncorrectable error pulse |
| ue_addr | input | ERR_AW | Address of the uncorrectable error |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench uses the default parameters: 32-bit error addresses and a configuration reset value of 0x90. With these, both captured-address registers fill the whole read word, and the reset value sets both configuration bits. The counter widths are fixed by the field layout at 8 and 4 bits, so a burst of a few hundred back-to-back pulses drives both counters into saturation within a short run. One case is a pulse that arrives on the edge where the clear bit rises and again while it is held. Another is a second uncorrectable error that must not displace the first address.

// File: rtl/ecc_errlog_pkg.sv
package ecc_errlog_pkg;

    localparam int WORD_W   = 32;
    localparam int BUS_AW   = 8;
    localparam int CE_CNT_W = 8;
    localparam int UE_CNT_W = 4;

    localparam logic [BUS_AW-1:0] OFS_KEY = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_CFG = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_CTL = 8'h50;
    localparam logic [BUS_AW-1:0] OFS_UEA = 8'h58;
    localparam logic [BUS_AW-1:0] OFS_CEA = 8'h5C;

    localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'hFC60_0309;
    localparam logic [WORD_W-1:0] LOCK_KEY   = ~UNLOCK_KEY;

    localparam int CTL_CLR_BIT  = 31;
    localparam int CTL_CE_LSB   = 16;
    localparam int CTL_UE_LSB   = 12;
    localparam int CTL_CE_EN    = 0;
    localparam int CTL_UE_EN    = 1;
    localparam int CFG_ECC_BIT  = 7;
    localparam int CFG_TYPE_BIT = 4;

    typedef enum logic [2:0] {
        SEL_KEY,
        SEL_CFG,
        SEL_CTL,
        SEL_UEA,
        SEL_CEA,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic {
        ST_LOCKED   = 1'b0,
        ST_UNLOCKED = 1'b1
    } lock_e;

    typedef struct packed {
        logic clr;
        logic ue_en;
        logic ce_en;
    } ctl_t;

    typedef struct packed {
        logic ecc_on;
        logic ddr4;
    } cfg_t;

    function automatic reg_sel_e decode_ofs(input logic [BUS_AW-1:0] ofs);
        case (ofs)
            OFS_KEY: return SEL_KEY;
            OFS_CFG: return SEL_CFG;
            OFS_CTL: return SEL_CTL;
            OFS_UEA: return SEL_UEA;
            OFS_CEA: return SEL_CEA;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        cfg_t c;
        c.ecc_on = w[CFG_ECC_BIT];
        c.ddr4   = w[CFG_TYPE_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CFG_ECC_BIT]  = c.ecc_on;
        w[CFG_TYPE_BIT] = c.ddr4;
        return w;
    endfunction

endpackage

// File: rtl/errlog_keylock.sv
module errlog_keylock
    import ecc_errlog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr,
    input  logic [WORD_W-1:0] key_data,
    output logic              unlocked
);

    lock_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LOCKED;
        end else if (key_wr) begin
            if (key_data == UNLOCK_KEY) begin
                state <= ST_UNLOCKED;
            end else if (key_data == LOCK_KEY) begin
                state <= ST_LOCKED;
            end
        end
    end

    assign unlocked = (state == ST_UNLOCKED);

    // R2: the exact key opens the register set
    a_r2_key_opens: assert property (@(posedge clk) disable iff (rst)
        key_wr && key_data == UNLOCK_KEY |=> unlocked);

    // R2: the inverse key closes it
    a_r2_inverse_closes: assert property (@(posedge clk) disable iff (rst)
        key_wr && key_data == LOCK_KEY |=> !unlocked);

    // R2: any other value leaves the state alone
    a_r2_other_holds: assert property (@(posedge clk) disable iff (rst)
        key_wr && key_data != UNLOCK_KEY && key_data != LOCK_KEY |=> $stable(unlocked));

endmodule

// File: rtl/errlog_tally.sv
module errlog_tally #(
    parameter int CNT_W      = 8,
    parameter int AW         = 32,
    parameter bit KEEP_FIRST = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             hit,
    input  logic [AW-1:0]    hit_addr,
    output logic [CNT_W-1:0] cnt,
    output logic [AW-1:0]    cap_addr
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_max;
    logic take_addr;

    assign at_max = (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (hit && !at_max) begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (KEEP_FIRST) begin : g_first
            assign take_addr = hit && (cnt == '0);
        end else begin : g_latest
            assign take_addr = hit;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cap_addr <= '0;
        end else if (take_addr) begin
            cap_addr <= hit_addr;
        end
    end

    // R4: a full counter stays full
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        at_max && !clr |=> cnt == CNT_MAX);

    // R4: one step per pulse below the limit
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        hit && !clr && !at_max |=> cnt == $past(cnt) + 1'b1);

    // R5: a held clear zeroes count and address
    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0 && cap_addr == '0);

    generate
        if (KEEP_FIRST) begin : g_chk_first
            // R6: once logged, the first address is kept
            a_r6_first_kept: assert property (@(posedge clk) disable iff (rst)
                cnt != '0 && !clr |=> $stable(cap_addr));
        end else begin : g_chk_latest
            // R7: every pulse replaces the address
            a_r7_latest_taken: assert property (@(posedge clk) disable iff (rst)
                hit && !clr |=> cap_addr == $past(hit_addr));
        end
    endgenerate

endmodule

// File: rtl/ecc_errlog.sv
module ecc_errlog
    import ecc_errlog_pkg::*;
#(
    parameter int          ERR_AW    = 32,
    parameter logic [31:0] CFG_RESET = 32'h0000_0090
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ce_hit,
    input  logic [ERR_AW-1:0] ce_addr,
    input  logic              ue_hit,
    input  logic [ERR_AW-1:0] ue_addr,
    output logic              irq
);

    reg_sel_e sel;
    logic     unlocked;
    logic     key_wr;
    logic     cfg_wr;
    logic     ctl_wr;
    ctl_t     ctl_q;
    cfg_t     cfg_q;

    logic [CE_CNT_W-1:0] ce_cnt;
    logic [UE_CNT_W-1:0] ue_cnt;
    logic [ERR_AW-1:0]   ce_cap;
    logic [ERR_AW-1:0]   ue_cap;
    logic [WORD_W-1:0]   ctl_word;

    assign sel    = decode_ofs(bus_addr);
    assign key_wr = bus_wr && (sel == SEL_KEY);
    assign cfg_wr = bus_wr && unlocked && (sel == SEL_CFG);
    assign ctl_wr = bus_wr && unlocked && (sel == SEL_CTL);

    errlog_keylock u_lock (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (key_wr),
        .key_data (bus_wdata),
        .unlocked (unlocked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_from_word(CFG_RESET);
        end else if (cfg_wr) begin
            cfg_q <= cfg_from_word(bus_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q.clr   <= bus_wdata[CTL_CLR_BIT];
            ctl_q.ue_en <= bus_wdata[CTL_UE_EN];
            ctl_q.ce_en <= bus_wdata[CTL_CE_EN];
        end
    end

    errlog_tally #(
        .CNT_W      (CE_CNT_W),
        .AW         (ERR_AW),
        .KEEP_FIRST (1'b0)
    ) u_ce (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl_q.clr),
        .hit      (ce_hit),
        .hit_addr (ce_addr),
        .cnt      (ce_cnt),
        .cap_addr (ce_cap)
    );

    errlog_tally #(
        .CNT_W      (UE_CNT_W),
        .AW         (ERR_AW),
        .KEEP_FIRST (1'b1)
    ) u_ue (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl_q.clr),
        .hit      (ue_hit),
        .hit_addr (ue_addr),
        .cnt      (ue_cnt),
        .cap_addr (ue_cap)
    );

    always_comb begin
        ctl_word = '0;
        ctl_word[CTL_CLR_BIT] = ctl_q.clr;
        ctl_word[CTL_CE_LSB +: CE_CNT_W] = ce_cnt;
        ctl_word[CTL_UE_LSB +: UE_CNT_W] = ue_cnt;
        ctl_word[CTL_UE_EN] = ctl_q.ue_en;
        ctl_word[CTL_CE_EN] = ctl_q.ce_en;
    end

    always_comb begin
        case (sel)
            SEL_KEY: bus_rdata = {{(WORD_W-1){1'b0}}, unlocked};
            SEL_CFG: bus_rdata = cfg_to_word(cfg_q);
            SEL_CTL: bus_rdata = ctl_word;
            SEL_UEA: bus_rdata = WORD_W'(ue_cap);
            SEL_CEA: bus_rdata = WORD_W'(ce_cap);
            default: bus_rdata = '0;
        endcase
    end

    assign irq = (ctl_q.ce_en && ce_cnt != '0) || (ctl_q.ue_en && ue_cnt != '0);

    // R3: a locked write cannot move the control bits
    a_r3_locked_ctl: assert property (@(posedge clk) disable iff (rst)
        !unlocked && bus_wr && sel == SEL_CTL |=> $stable(ctl_q));

    // R3: a locked write cannot move the configuration
    a_r3_locked_cfg: assert property (@(posedge clk) disable iff (rst)
        !unlocked && bus_wr && sel == SEL_CFG |=> $stable(cfg_q));

    // R8: a cycle of clear leaves the interrupt low
    a_r8_clear_quiets: assert property (@(posedge clk) disable iff (rst)
        ctl_q.clr |=> !irq);

    // R8: no enables, no interrupt
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.ce_en && !ctl_q.ue_en |-> !irq);

    // R10: unmapped offsets read zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        sel == SEL_NONE |-> bus_rdata == '0);

endmodule

// File: tb/tb_ecc_errlog.sv
module tb_ecc_errlog;

    localparam int          AW    = 32;
    localparam logic [31:0] KEY   = 32'hFC60_0309;
    localparam logic [31:0] CFG_R = 32'h0000_0090;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    bus_addr = 8'h00;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          ce_hit = 1'b0;
    logic [AW-1:0] ce_addr = '0;
    logic          ue_hit = 1'b0;
    logic [AW-1:0] ue_addr = '0;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference state
    bit          m_unl;
    int unsigned m_cfg, m_ce, m_ue;
    bit          m_clr, m_cen, m_uen;
    logic [31:0] m_cea, m_uea;

    ecc_errlog #(.ERR_AW(AW), .CFG_RESET(CFG_R)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ce_hit    (ce_hit),
        .ce_addr   (ce_addr),
        .ue_hit    (ue_hit),
        .ue_addr   (ue_addr),
        .irq       (irq)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return {31'd0, m_unl};
            8'h04: return m_cfg;
            8'h50: return {m_clr, 7'd0, m_ce[7:0], m_ue[3:0], 10'd0, m_uen, m_cen};
            8'h58: return m_uea;
            8'h5C: return m_cea;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit old_clr, old_unl;
        old_clr = m_clr;
        old_unl = m_unl;
        if (rst) begin
            m_unl = 0; m_cfg = CFG_R & 32'h90; m_clr = 0; m_cen = 0; m_uen = 0;
            m_ce = 0; m_ue = 0; m_cea = 0; m_uea = 0;
        end else begin
            if (old_clr) begin
                m_ce = 0; m_ue = 0; m_cea = 0; m_uea = 0;
            end else begin
                if (ce_hit) begin
                    if (m_ce < 255) m_ce++;
                    m_cea = ce_addr;
                end
                if (ue_hit) begin
                    if (m_ue == 0) m_uea = ue_addr;
                    if (m_ue < 15) m_ue++;
                end
            end
            if (bus_wr && bus_addr == 8'h00) begin
                if (bus_wdata == KEY) m_unl = 1;
                else if (bus_wdata == ~KEY) m_unl = 0;
            end else if (bus_wr && old_unl && bus_addr == 8'h04) begin
                m_cfg = bus_wdata & 32'h90;
            end else if (bus_wr && old_unl && bus_addr == 8'h50) begin
                m_clr = bus_wdata[31]; m_uen = bus_wdata[1]; m_cen = bus_wdata[0];
            end
        end
    end

    // every-clock comparison against the reference
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            logic expirq;
            expirq = (m_cen && m_ce != 0) || (m_uen && m_ue != 0);
            checks++;
            if (irq !== expirq) begin
                fails++;
                $display("FAIL R8 per-clock irq actual=%0b expected=%0b", irq, expirq);
            end
            checks++;
            if (bus_rdata !== model_read(bus_addr)) begin
                fails++;
                $display("FAIL R10 per-clock read @%h actual=%h expected=%h",
                         bus_addr, bus_rdata, model_read(bus_addr));
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic err(input bit c, input bit u, input logic [31:0] ca, input logic [31:0] ua);
        @(negedge clk);
        ce_hit = c; ue_hit = u; ce_addr = ca; ue_addr = ua;
        @(negedge clk);
        ce_hit = 1'b0; ue_hit = 1'b0;
    endtask

    task automatic irq_is(input bit exp, input string tag);
        @(negedge clk);
        check(tag, {31'd0, irq}, {31'd0, exp});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h50, 32'h0, "R1 ctl after reset");
        rd(8'h58, 32'h0, "R1 ue addr after reset");
        rd(8'h5C, 32'h0, "R1 ce addr after reset");
        rd(8'h04, 32'h90, "R1 cfg after reset");
        rd(8'h00, 32'h0, "R1 locked after reset");
        irq_is(1'b0, "R1 irq after reset");

        // R3 locked writes ignored
        wr(8'h50, 32'h0000_0003);
        rd(8'h50, 32'h0, "R3 locked ctl write ignored");
        wr(8'h04, 32'h0);
        rd(8'h04, 32'h90, "R3 locked cfg write ignored");

        // R2 key handling
        wr(8'h00, 32'h1234_5678);
        rd(8'h00, 32'h0, "R2 wrong key keeps lock");
        wr(8'h00, KEY);
        rd(8'h00, 32'h1, "R2 key unlocks");

        // R9 configuration bits
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h90, "R9 cfg only bits 7 and 4");
        wr(8'h04, 32'h0000_0010);
        rd(8'h04, 32'h10, "R9 ddr4 select alone");
        wr(8'h04, 32'h0000_0080);
        rd(8'h04, 32'h80, "R9 ecc bit alone");

        // R10 unmapped reads
        rd(8'h08, 32'h0, "R10 unmapped 0x08");
        rd(8'h60, 32'h0, "R10 unmapped 0x60");
        rd(8'hFC, 32'h0, "R10 unmapped 0xFC");

        // R4 / R7 correctable path
        err(1, 0, 32'hA000_0010, 32'h0);
        err(1, 0, 32'hA000_0020, 32'h0);
        err(1, 0, 32'hA000_0030, 32'h0);
        rd(8'h50, 32'h0003_0000, "R4 ce count three");
        rd(8'h5C, 32'hA000_0030, "R7 latest ce address");

        // R4 / R6 uncorrectable path, one with a simultaneous ce
        err(0, 1, 32'h0, 32'hB000_0100);
        err(1, 1, 32'hA000_0040, 32'hB000_0200);
        rd(8'h50, 32'h0004_2000, "R4 counts four and two");
        rd(8'h58, 32'hB000_0100, "R6 first ue address kept");
        rd(8'h5C, 32'hA000_0040, "R7 ce address replaced");

        // R10 count bits are read-only
        wr(8'h50, 32'h00FF_F000);
        rd(8'h50, 32'h0004_2000, "R10 count write ignored");

        // R8 enables
        irq_is(1'b0, "R8 disabled no irq");
        wr(8'h50, 32'h1);
        irq_is(1'b1, "R8 ce enable raises irq");
        wr(8'h50, 32'h2);
        irq_is(1'b1, "R8 ue enable raises irq");
        wr(8'h50, 32'h0);
        irq_is(1'b0, "R8 enables off drops irq");
        wr(8'h50, 32'h3);

        // R5 clear with pulses on the rising edge and while held
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h50; bus_wdata = 32'h8000_0003;
        ce_hit = 1'b1; ue_hit = 1'b1; ce_addr = 32'hC0C0_0001; ue_addr = 32'hD0D0_0001;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        ce_hit = 1'b0; ue_hit = 1'b0;
        rd(8'h50, 32'h8000_0003, "R5 clear held zeroes counts");
        rd(8'h58, 32'h0, "R5 clear zeroes ue address");
        rd(8'h5C, 32'h0, "R5 clear zeroes ce address");
        irq_is(1'b0, "R5 irq low during clear");
        wr(8'h50, 32'h3);
        rd(8'h50, 32'h3, "R5 released clear starts empty");
        err(1, 0, 32'hE000_0004, 32'h0);
        rd(8'h50, 32'h0001_0003, "R5 counting resumes");
        irq_is(1'b1, "R8 irq after new ce");

        // R4 saturation of both counters, R6 first address survives
        @(negedge clk);
        ce_hit = 1'b1; ue_hit = 1'b1; ue_addr = 32'hF000_0000; ce_addr = 32'hF111_0000;
        repeat (300) begin
            @(negedge clk);
            ue_addr = ue_addr + 32'h4;
            ce_addr = ce_addr + 32'h4;
        end
        ce_hit = 1'b0; ue_hit = 1'b0;
        rd(8'h50, 32'h00FF_F003, "R4 both counters saturate");
        rd(8'h58, 32'hF000_0000, "R6 first ue address after burst");
        rd(8'h5C, 32'hF111_0000 + 32'd299 * 32'h4, "R7 last ce of burst");

        // R2 relock
        wr(8'h00, ~KEY);
        rd(8'h00, 32'h0, "R2 inverse key locks");
        wr(8'h50, 32'h0);
        rd(8'h50, 32'h00FF_F003, "R3 relocked write ignored");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule